// File: doc/BRIEF.md
# Split-Address 32-bit Wishbone Bridge

This block connects a narrow peripheral register bus with a half-word data path to a full-word Wishbone classic master port. Software sees a small bank of half-word registers: a control word, a low and a high half for a read address, a low and a high half for a write address, and a low and a high data half. The low address half is stored first; storing the high half supplies the upper address bits and starts a single bus cycle straight away. Which register pair was written decides whether the cycle reads or writes.

A write cycle carries the two data halves as its full-word payload. A read cycle puts the slave's returned word back into the data halves. A four-bit byte-enable field in the control word drives the select lines. Bit 15 of the control word reports a pending flag that software polls. Only one cycle may be outstanding. A missing acknowledge ends the cycle after a fixed number of clocks, so the bridge never locks up.

Top module: `wbb_bridge`

## Requirements
- R1: After reset, wb_cyc_o, wb_stb_o and wb_sel_o are 0 and a control read returns 0. A transfer launched before any control write drives wb_sel_o = 0.
- R2: A write to word index 2 (read-address high) while idle starts a read cycle. From the next clock on, wb_cyc_o = wb_stb_o = 1, wb_we_o = 0 and wb_adr_o = {written value, stored word-1 value}.
- R3: A write to word index 4 (write-address high) while idle starts a write cycle. It has wb_we_o = 1, wb_adr_o = {written value, stored word-3 value} and wb_dat_o = {word 6, word 5}. The data words are left unchanged afterwards.
- R4: Bits 3:0 of a write to word index 0 set the byte enables, which appear on wb_sel_o for every later transfer. A read of word 0 returns 0 in bits 14:0.
- R5: Bit 15 of a word-0 read is 1 from the clock after a launch until the clock on which the cycle ends, and 0 otherwise.
- R6: wb_cyc_o and wb_stb_o stay high, with the address and direction stable, until wb_ack_i is seen. They fall on the following clock. An acknowledge after N wait cycles gives N+1 clocks of wb_cyc_o.
- R7: On the acknowledge of a read cycle, wb_dat_i is captured. Word 5 then reads bits 15:0 of the captured word and word 6 reads bits 31:16.
- R8: Words 5 and 6 can be written and read back by software.
- R9: While a cycle is pending, writes to words 1 to 4 are ignored. No new cycle starts and the stored low halves keep their old values.
- R10: A cycle with no acknowledge ends after exactly TIMEOUT clocks of wb_cyc_o. The pending flag then clears, the data words keep their values, and the next launch works normally.
- R11: Word index 7 is reserved: it reads 0, and writes to it start no cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_we_i | input | 1 | Register write strobe |
| bus_re_i | input | 1 | Register read enable |
| bus_addr_i | input | 3 | Register word index |
| bus_wdata_i | input | 16 | Register write data |
| bus_rdata_o | output | 16 | Register read data, 0 when not reading |
| wb_adr_o | output | 32 | Wishbone address |
| wb_dat_o | output | 32 | Wishbone write data |
| wb_dat_i | input | 32 | Wishbone read data |
| wb_we_o | output | 1 | Wishbone write enable |
| wb_sel_o | output | 4 | Wishbone byte selects |
| wb_stb_o | output | 1 | Wishbone strobe |
| wb_cyc_o | output | 1 | Wishbone cycle |
| wb_ack_i | input | 1 | Wishbone acknowledge |

## Verification
A corrupted stored low address half shows up on wb_adr_o on the clock after the next high-half write. A stale latched byte-enable or direction appears on that same clock. Faulty busy state becomes visible in the control word's bit 15 within one clock: it fails to rise, fails to fall after an acknowledge, or lets an ignored address write start a second cycle, which the scoreboard sees as an unexpected acknowledge. A broken timeout counter changes the count of wb_cyc_o clocks, or hangs the poll, during the single unacknowledged cycle.

// File: rtl/wbb_pkg.sv
package wbb_pkg;
  typedef enum logic [2:0] {
    IDX_CTRL    = 3'd0,
    IDX_RADR_LO = 3'd1,
    IDX_RADR_HI = 3'd2,
    IDX_WADR_LO = 3'd3,
    IDX_WADR_HI = 3'd4,
    IDX_DAT_LO  = 3'd5,
    IDX_DAT_HI  = 3'd6,
    IDX_RSVD    = 3'd7
  } wbb_idx_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } wbb_state_e;
endpackage

// File: rtl/wbb_tmo.sv
module wbb_tmo #(
  parameter int TIMEOUT = 255
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic expire_o
);
  localparam int CNT_W = $clog2(TIMEOUT + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (run_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = run_i && (cnt_q == CNT_W'(TIMEOUT - 1));

  assert_cnt_bound_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q < CNT_W'(TIMEOUT)));
endmodule

// File: rtl/wbb_regs.sv
module wbb_regs
  import wbb_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int IDX_W  = 3,
  localparam int FULL_W = 2 * HALF_W,
  localparam int SEL_W  = FULL_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [HALF_W-1:0] wdata_i,
  output logic [HALF_W-1:0] rdata_o,
  input  logic              pending_i,
  input  logic              cap_i,
  input  logic [FULL_W-1:0] cap_data_i,
  output logic              launch_o,
  output logic              launch_we_o,
  output logic [FULL_W-1:0] launch_adr_o,
  output logic [FULL_W-1:0] launch_dat_o,
  output logic [SEL_W-1:0]  launch_sel_o
);
  logic [HALF_W-1:0] radr_lo_q, wadr_lo_q, dat_lo_q, dat_hi_q;
  logic [SEL_W-1:0]  sel_q;
  logic              adr_ok;

  function automatic logic hit(input logic [IDX_W-1:0] idx, input wbb_idx_e target);
    return idx == IDX_W'(target);
  endfunction

  assign adr_ok = we_i && !pending_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      radr_lo_q <= '0;
      wadr_lo_q <= '0;
      sel_q     <= '0;
    end else begin
      if (adr_ok && hit(idx_i, IDX_RADR_LO)) radr_lo_q <= wdata_i;
      if (adr_ok && hit(idx_i, IDX_WADR_LO)) wadr_lo_q <= wdata_i;
      if (we_i && hit(idx_i, IDX_CTRL))      sel_q     <= wdata_i[SEL_W-1:0];
    end
  end

  // returned read data wins over a software write in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dat_lo_q <= '0;
      dat_hi_q <= '0;
    end else if (cap_i) begin
      dat_lo_q <= cap_data_i[HALF_W-1:0];
      dat_hi_q <= cap_data_i[FULL_W-1:HALF_W];
    end else begin
      if (we_i && hit(idx_i, IDX_DAT_LO)) dat_lo_q <= wdata_i;
      if (we_i && hit(idx_i, IDX_DAT_HI)) dat_hi_q <= wdata_i;
    end
  end

  logic go_rd, go_wr;
  assign go_rd        = adr_ok && hit(idx_i, IDX_RADR_HI);
  assign go_wr        = adr_ok && hit(idx_i, IDX_WADR_HI);
  assign launch_o     = go_rd || go_wr;
  assign launch_we_o  = go_wr;
  assign launch_adr_o = {wdata_i, go_wr ? wadr_lo_q : radr_lo_q};
  assign launch_dat_o = {dat_hi_q, dat_lo_q};
  assign launch_sel_o = sel_q;

  always_comb begin
    rdata_o = '0;
    if (re_i) begin
      unique case (idx_i)
        IDX_W'(IDX_CTRL):   rdata_o[HALF_W-1] = pending_i;
        IDX_W'(IDX_DAT_LO): rdata_o = dat_lo_q;
        IDX_W'(IDX_DAT_HI): rdata_o = dat_hi_q;
        default:            rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/wbb_master.sv
module wbb_master
  import wbb_pkg::*;
#(
  parameter int FULL_W  = 32,
  parameter int TIMEOUT = 255,
  localparam int SEL_W  = FULL_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  logic              launch_we_i,
  input  logic [FULL_W-1:0] launch_adr_i,
  input  logic [FULL_W-1:0] launch_dat_i,
  input  logic [SEL_W-1:0]  launch_sel_i,
  output logic              pending_o,
  output logic              cap_o,
  output logic [FULL_W-1:0] cap_data_o,
  output logic [FULL_W-1:0] wb_adr_o,
  output logic [FULL_W-1:0] wb_dat_o,
  input  logic [FULL_W-1:0] wb_dat_i,
  output logic              wb_we_o,
  output logic [SEL_W-1:0]  wb_sel_o,
  output logic              wb_stb_o,
  output logic              wb_cyc_o,
  input  logic              wb_ack_i
);
  wbb_state_e        state_q;
  logic              busy, expire;
  logic [FULL_W-1:0] adr_q, dat_q;
  logic [SEL_W-1:0]  sel_q;
  logic              we_q;

  assign busy = (state_q == ST_BUSY);

  wbb_tmo #(.TIMEOUT(TIMEOUT)) u_tmo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (launch_i),
    .run_i   (busy),
    .expire_o(expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      adr_q   <= '0;
      dat_q   <= '0;
      sel_q   <= '0;
      we_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (launch_i) begin
          state_q <= ST_BUSY;
          adr_q   <= launch_adr_i;
          dat_q   <= launch_dat_i;
          sel_q   <= launch_sel_i;
          we_q    <= launch_we_i;
        end
        ST_BUSY: if (wb_ack_i || expire) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign pending_o  = busy;
  assign cap_o      = busy && wb_ack_i && !we_q;
  assign cap_data_o = wb_dat_i;
  assign wb_adr_o   = adr_q;
  assign wb_dat_o   = dat_q;
  assign wb_sel_o   = sel_q;
  assign wb_we_o    = we_q;
  assign wb_stb_o   = busy;
  assign wb_cyc_o   = busy;

  assert_launch_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i |-> !busy);
  assert_launch_adr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i |=> busy && (adr_q == $past(launch_adr_i)) && (we_q == $past(launch_we_i)));
  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !wb_ack_i && !expire) |=> busy && $stable(adr_q) && $stable(we_q) && $stable(sel_q));
  assert_drop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && wb_ack_i) |=> !busy);
endmodule

// File: rtl/wbb_bridge.sv
module wbb_bridge #(
  parameter int HALF_W  = 16,
  parameter int IDX_W   = 3,
  parameter int TIMEOUT = 255,
  localparam int FULL_W = 2 * HALF_W,
  localparam int SEL_W  = FULL_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic              bus_re_i,
  input  logic [IDX_W-1:0]  bus_addr_i,
  input  logic [HALF_W-1:0] bus_wdata_i,
  output logic [HALF_W-1:0] bus_rdata_o,
  output logic [FULL_W-1:0] wb_adr_o,
  output logic [FULL_W-1:0] wb_dat_o,
  input  logic [FULL_W-1:0] wb_dat_i,
  output logic              wb_we_o,
  output logic [SEL_W-1:0]  wb_sel_o,
  output logic              wb_stb_o,
  output logic              wb_cyc_o,
  input  logic              wb_ack_i
);
  logic              pending, cap, launch, launch_we;
  logic [FULL_W-1:0] cap_data, launch_adr, launch_dat;
  logic [SEL_W-1:0]  launch_sel;

  wbb_regs #(.HALF_W(HALF_W), .IDX_W(IDX_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (bus_we_i),
    .re_i        (bus_re_i),
    .idx_i       (bus_addr_i),
    .wdata_i     (bus_wdata_i),
    .rdata_o     (bus_rdata_o),
    .pending_i   (pending),
    .cap_i       (cap),
    .cap_data_i  (cap_data),
    .launch_o    (launch),
    .launch_we_o (launch_we),
    .launch_adr_o(launch_adr),
    .launch_dat_o(launch_dat),
    .launch_sel_o(launch_sel)
  );

  wbb_master #(.FULL_W(FULL_W), .TIMEOUT(TIMEOUT)) u_master (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .launch_i    (launch),
    .launch_we_i (launch_we),
    .launch_adr_i(launch_adr),
    .launch_dat_i(launch_dat),
    .launch_sel_i(launch_sel),
    .pending_o   (pending),
    .cap_o       (cap),
    .cap_data_o  (cap_data),
    .wb_adr_o    (wb_adr_o),
    .wb_dat_o    (wb_dat_o),
    .wb_dat_i    (wb_dat_i),
    .wb_we_o     (wb_we_o),
    .wb_sel_o    (wb_sel_o),
    .wb_stb_o    (wb_stb_o),
    .wb_cyc_o    (wb_cyc_o),
    .wb_ack_i    (wb_ack_i)
  );
endmodule

// File: tb/wbb_bridge_tb_top.sv
module wbb_bridge_tb_top;
  localparam int TMO = 255;
  localparam int NEVER = 100000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_we_i = 1'b0, bus_re_i = 1'b0;
  logic [2:0]  bus_addr_i = '0;
  logic [15:0] bus_wdata_i = '0;
  logic [15:0] bus_rdata_o;
  logic [31:0] wb_adr_o, wb_dat_o, wb_dat_i;
  logic        wb_we_o, wb_stb_o, wb_cyc_o, wb_ack_i;
  logic [3:0]  wb_sel_o;

  always #4 clk_i = ~clk_i;

  wbb_bridge #(.TIMEOUT(TMO)) dut_i (.*);

  typedef struct { logic [31:0] adr; logic [31:0] dat; logic we; logic [3:0] sel; } xfer_t;
  xfer_t expq[$];

  int tests = 0, fails = 0, cyc_cycles = 0, ack_delay = 0, wait_cnt = 0, cyc_total = 0;

  function automatic logic [31:0] slave_word(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A5A, a[31:16] ^ 16'hC3C3};
  endfunction

  assign wb_dat_i = slave_word(wb_adr_o);
  assign wb_ack_i = wb_cyc_o && wb_stb_o && (wait_cnt == ack_delay);

  always @(posedge clk_i) wait_cnt <= wb_cyc_o ? wait_cnt + 1 : 0;
  always @(negedge clk_i) begin
    if (wb_cyc_o) cyc_cycles <= cyc_cycles + 1;
    cyc_total <= cyc_total + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (wb_cyc_o && wb_stb_o && wb_ack_i) begin
      if (expq.size() == 0) chk("R9 unexpected cycle", wb_adr_o, 32'hx);
      else begin
        xfer_t e;
        e = expq.pop_front();
        chk("R2 R3 adr", wb_adr_o, e.adr);
        chk("R2 R3 we", {31'd0, wb_we_o}, {31'd0, e.we});
        chk("R4 sel", {28'd0, wb_sel_o}, {28'd0, e.sel});
        if (e.we) chk("R3 dat", wb_dat_o, e.dat);
      end
    end
  end

  task automatic bus_wr(input logic [2:0] idx, input logic [15:0] d);
    @(negedge clk_i);
    bus_we_i = 1'b1; bus_addr_i = idx; bus_wdata_i = d;
    @(negedge clk_i);
    bus_we_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] idx, output logic [15:0] v);
    bus_re_i = 1'b1; bus_addr_i = idx;
    #1 v = bus_rdata_o;
    bus_re_i = 1'b0;
  endtask

  task automatic wait_idle();
    logic [15:0] v;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk_i);
      bus_rd(3'd0, v);
      if (!v[15]) break;
    end
  endtask

  task automatic push(input logic [31:0] a, input logic [31:0] d, input logic w, input logic [3:0] s);
    xfer_t e;
    e.adr = a; e.dat = d; e.we = w; e.sel = s;
    expq.push_back(e);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] v, lo, hi;
    int c0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 cyc", {31'd0, wb_cyc_o}, 0);
    chk("R1 stb", {31'd0, wb_stb_o}, 0);
    chk("R1 sel", {28'd0, wb_sel_o}, 0);
    bus_rd(3'd0, v); chk("R1 ctrl", {16'd0, v}, 0);
    // R11 reserved slot
    bus_wr(3'd7, 16'hFFFF);
    chk("R11 no cycle", {31'd0, wb_cyc_o}, 0);
    bus_rd(3'd7, v); chk("R11 read zero", {16'd0, v}, 0);
    // R8 data registers
    bus_wr(3'd5, 16'h1234); bus_wr(3'd6, 16'hABCD);
    bus_rd(3'd5, v); chk("R8 dat lo", {16'd0, v}, 32'h1234);
    bus_rd(3'd6, v); chk("R8 dat hi", {16'd0, v}, 32'hABCD);
    // R2 read before any ctrl write: sel 0 (R1), immediate ack
    ack_delay = 0;
    bus_wr(3'd1, 16'h0010);
    push(32'h0001_0010, 0, 1'b0, 4'h0);
    c0 = cyc_cycles;
    bus_wr(3'd2, 16'h0001);
    chk("R2 cyc after launch", {31'd0, wb_cyc_o}, 1);
    chk("R2 we", {31'd0, wb_we_o}, 0);
    chk("R1 sel default", {28'd0, wb_sel_o}, 0);
    bus_rd(3'd0, v); chk("R5 pending high", {31'd0, v[15]}, 1);
    wait_idle();
    chk("R6 cyc length delay0", cyc_cycles - c0, 1);
    bus_rd(3'd0, v); chk("R5 pending low", {16'd0, v}, 0);
    bus_rd(3'd5, lo); bus_rd(3'd6, hi);
    chk("R7 read data", {hi, lo}, slave_word(32'h0001_0010));
    // R3 write with full selects, delay 3
    bus_wr(3'd0, 16'hFFFF);
    bus_rd(3'd0, v); chk("R4 ctrl bits hidden", {16'd0, v}, 0);
    bus_wr(3'd5, 16'hBEEF); bus_wr(3'd6, 16'hDEAD);
    bus_wr(3'd3, 16'h0400);
    ack_delay = 3;
    push(32'h8000_0400, 32'hDEAD_BEEF, 1'b1, 4'hF);
    c0 = cyc_cycles;
    bus_wr(3'd4, 16'h8000);
    chk("R3 we", {31'd0, wb_we_o}, 1);
    chk("R3 wb_dat_o", wb_dat_o, 32'hDEAD_BEEF);
    wait_idle();
    chk("R6 cyc length delay3", cyc_cycles - c0, 4);
    bus_rd(3'd5, lo); bus_rd(3'd6, hi);
    chk("R3 data kept", {hi, lo}, 32'hDEAD_BEEF);
    // R9 address writes while pending are ignored
    bus_wr(3'd0, 16'h0005);
    bus_wr(3'd1, 16'h0020);
    ack_delay = 6;
    push(32'h0002_0020, 0, 1'b0, 4'h5);
    c0 = cyc_cycles;
    bus_wr(3'd2, 16'h0002);
    bus_wr(3'd1, 16'hFFFF);
    bus_wr(3'd2, 16'h7777);
    bus_wr(3'd4, 16'h6666);
    wait_idle();
    chk("R9 single cycle length", cyc_cycles - c0, 7);
    chk("R9 queue drained", expq.size(), 0);
    ack_delay = 0;
    push(32'h0009_0020, 0, 1'b0, 4'h5);
    bus_wr(3'd2, 16'h0009);
    chk("R9 low half kept", wb_adr_o, 32'h0009_0020);
    wait_idle();
    bus_rd(3'd5, lo); bus_rd(3'd6, hi);
    chk("R7 second read data", {hi, lo}, slave_word(32'h0009_0020));
    // R10 timeout
    ack_delay = NEVER;
    c0 = cyc_cycles;
    bus_wr(3'd2, 16'h00AA);
    wait_idle();
    chk("R10 timeout length", cyc_cycles - c0, TMO);
    bus_rd(3'd0, v); chk("R10 pending cleared", {16'd0, v}, 0);
    bus_rd(3'd5, lo); bus_rd(3'd6, hi);
    chk("R10 data unchanged", {hi, lo}, slave_word(32'h0009_0020));
    ack_delay = 1;
    push(32'h0003_0400, 32'h5555_AAAA, 1'b1, 4'h5);
    bus_wr(3'd5, 16'hAAAA); bus_wr(3'd6, 16'h5555);
    bus_wr(3'd4, 16'h0003);
    wait_idle();
    chk("R10 recovery drained", expq.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule